// File: doc/BRIEF.md
# Sobel Edge Closing Overlay

This block marks edges in a small video frame and paints them over the colour picture. It takes a grayscale plane together with three colour planes (red, green, blue), one pixel per valid beat, starting at a pixel flagged as start-of-frame. It stores one frame, finds edges in the grayscale plane with a 3x3 Sobel operator and a fixed threshold, and cleans the binary edge map with a morphological closing that uses a plus-shaped 3x3 mask. It then streams the colour frame back out, adding a fixed magenta edge colour wherever the closed edge map is set.

Frame geometry is fixed by parameters. After the last pixel of a frame is taken, the block runs three internal passes of one pixel per cycle each: edge detection, dilation, and erosion with output. While these passes run it takes no input. Windowed operations treat pixels outside the frame as copies of the nearest border pixel.

Top module: `sobel_close_overlay`

## Requirements
- R1: While reset is held and after its release until a frame is output, out_valid, out_sof and out_eol are 0 and out_r, out_g, out_b are 0. They also read 0 on every cycle with out_valid low.
- R2: A frame begins at a beat with in_valid and in_sof both high, which becomes pixel (0,0). The following valid beats fill the frame in raster order, left to right and then top to bottom, until W*H pixels are held. Valid beats without in_sof before a frame has started are ignored. A beat with in_sof in the middle of a frame restarts it at pixel (0,0).
- R3: A pixel is an edge when |Gx|+|Gy| is greater than 4*THRESH (48 with the default THRESH of 12). Gx is the right column minus the left column of the 3x3 grayscale window, and Gy is the bottom row minus the top row, each with centre weight 2 and corner weight 1. A sum equal to the limit is not an edge.
- R4: In the Sobel window and in both closing steps, neighbours outside the frame take the value of the nearest pixel inside the frame (replicate padding).
- R5: The edge map is closed by a dilation, which is the OR over the centre pixel and its four direct neighbours, followed by an erosion, which is the AND over the same five pixels. This fills a one-pixel gap between two edge columns and does not widen a solid edge band.
- R6: Each output channel is the stored input channel plus the edge colour (R=255, G=0, B=255) when the closed edge bit is set, saturating at 255. Where the bit is clear the channel passes unchanged.
- R7: The first output pixel appears 2*W*H+1 cycles after the clock edge that takes the last input pixel. The W*H pixels follow on consecutive cycles in raster order. out_sof is high only on pixel (0,0), and out_eol is high on every pixel with column W-1.
- R8: Input beats are ignored from the edge that completes a frame up to and including the edge that outputs its last pixel. A frame start on the next edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | Input start-of-frame marker |
| in_gray | input | 8 | Smoothed grayscale pixel |
| in_r | input | 8 | Median-filtered red pixel |
| in_g | input | 8 | Median-filtered green pixel |
| in_b | input | 8 | Median-filtered blue pixel |
| out_valid | output | 1 | Output pixel qualifier |
| out_sof | output | 1 | Output start-of-frame marker |
| out_eol | output | 1 | Output end-of-line marker |
| out_r | output | 8 | Red with edge overlay |
| out_g | output | 8 | Green with edge overlay |
| out_b | output | 8 | Blue with edge overlay |

## Verification
The only latency is the one in R7: pixel i of a frame is due at the falling edge 2*W*H+2+i cycles after the falling edge on which the bench drove the last input pixel. The bench records that cycle number when it sends a frame and compares out_valid, the markers and all three channels against a behavioural model on every falling edge, so an early, late, missing or extra pixel fails on the cycle where it happens. The boundary frames are a threshold step of 12 and of 13, a three-pixel plateau whose centre column has no raw edge, and a flat frame for the borders. Junk input is driven up to the edge of the last output pixel, and the next frame follows on the very next edge.

// File: rtl/sobel_close_overlay.sv
module sobel_close_overlay #(
  parameter int W = 10,
  parameter int H = 8,
  parameter int THRESH = 12,
  parameter logic [7:0] EDGE_R = 8'd255,
  parameter logic [7:0] EDGE_G = 8'd0,
  parameter logic [7:0] EDGE_B = 8'd255
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_gray,
  input  logic [7:0] in_r,
  input  logic [7:0] in_g,
  input  logic [7:0] in_b,
  output logic       out_valid,
  output logic       out_sof,
  output logic       out_eol,
  output logic [7:0] out_r,
  output logic [7:0] out_g,
  output logic [7:0] out_b
);
  localparam int N   = W * H;
  localparam int XW  = $clog2(W);
  localparam int YW  = $clog2(H);
  localparam int PW  = $clog2(N);
  localparam int THR = THRESH * 4;
  localparam logic [XW-1:0] XMAX = XW'(W - 1);
  localparam logic [YW-1:0] YMAX = YW'(H - 1);
  localparam logic [PW-1:0] PMAX = PW'(N - 1);

  typedef enum logic [1:0] {S_IN, S_EDGE, S_DIL, S_OUT} st_t;
  st_t st;

  logic [7:0] gray_m [N];
  logic [7:0] red_m  [N];
  logic [7:0] grn_m  [N];
  logic [7:0] blu_m  [N];
  logic       edge_m [N];
  logic       dil_m  [N];

  logic [PW-1:0] idx;
  logic          filling;
  logic [XW-1:0] cx;
  logic [YW-1:0] cy;

  function automatic logic [PW-1:0] at(input logic [XW-1:0] x, input logic [YW-1:0] y);
    return PW'(int'(y) * W + int'(x));
  endfunction

  function automatic logic [7:0] sat(input logic [7:0] a, input logic [7:0] c, input logic e);
    logic [8:0] s;
    s = {1'b0, a} + (e ? {1'b0, c} : 9'd0);
    return s[8] ? 8'hFF : s[7:0];
  endfunction

  wire [XW-1:0] xm = (cx == '0)   ? cx : cx - 1'b1;
  wire [XW-1:0] xp = (cx == XMAX) ? cx : cx + 1'b1;
  wire [YW-1:0] ym = (cy == '0)   ? cy : cy - 1'b1;
  wire [YW-1:0] yp = (cy == YMAX) ? cy : cy + 1'b1;
  wire [PW-1:0] pc = at(cx, cy);
  wire          last = (cx == XMAX) && (cy == YMAX);

  wire          wr_en  = (st == S_IN) && in_valid && (in_sof || filling);
  wire [PW-1:0] wr_idx = in_sof ? '0 : idx;

  logic edge_now;
  always_comb begin
    int gx, gy, mag;
    gx = int'(gray_m[at(xp, ym)]) + 2 * int'(gray_m[at(xp, cy)]) + int'(gray_m[at(xp, yp)])
       - int'(gray_m[at(xm, ym)]) - 2 * int'(gray_m[at(xm, cy)]) - int'(gray_m[at(xm, yp)]);
    gy = int'(gray_m[at(xm, yp)]) + 2 * int'(gray_m[at(cx, yp)]) + int'(gray_m[at(xp, yp)])
       - int'(gray_m[at(xm, ym)]) - 2 * int'(gray_m[at(cx, ym)]) - int'(gray_m[at(xp, ym)]);
    mag = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    edge_now = mag > THR;
  end

  wire dil_now = edge_m[pc] | edge_m[at(xm, cy)] | edge_m[at(xp, cy)]
               | edge_m[at(cx, ym)] | edge_m[at(cx, yp)];
  wire ero_now = dil_m[pc] & dil_m[at(xm, cy)] & dil_m[at(xp, cy)]
               & dil_m[at(cx, ym)] & dil_m[at(cx, yp)];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      gray_m[wr_idx] <= in_gray;
      red_m[wr_idx]  <= in_r;
      grn_m[wr_idx]  <= in_g;
      blu_m[wr_idx]  <= in_b;
    end
    if (st == S_EDGE) edge_m[pc] <= edge_now;
    if (st == S_DIL)  dil_m[pc]  <= dil_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IN;
      idx     <= '0;
      filling <= 1'b0;
      cx      <= '0;
      cy      <= '0;
    end else if (st == S_IN) begin
      if (wr_en) begin
        if (wr_idx == PMAX) begin
          st      <= S_EDGE;
          idx     <= '0;
          filling <= 1'b0;
        end else begin
          idx     <= wr_idx + 1'b1;
          filling <= 1'b1;
        end
      end
    end else begin
      if (last) begin
        cx <= '0;
        cy <= '0;
        st <= (st == S_EDGE) ? S_DIL : (st == S_DIL) ? S_OUT : S_IN;
      end else if (cx == XMAX) begin
        cx <= '0;
        cy <= cy + 1'b1;
      end else begin
        cx <= cx + 1'b1;
      end
    end
  end

  wire emit = (st == S_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= emit;
      out_sof   <= emit && (cx == '0) && (cy == '0);
      out_eol   <= emit && (cx == XMAX);
      out_r     <= emit ? sat(red_m[pc], EDGE_R, ero_now) : '0;
      out_g     <= emit ? sat(grn_m[pc], EDGE_G, ero_now) : '0;
      out_b     <= emit ? sat(blu_m[pc], EDGE_B, ero_now) : '0;
    end
  end
endmodule

module sobel_close_overlay_chk #(
  parameter int W = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_sof,
  input logic       out_eol,
  input logic [7:0] out_r,
  input logic [7:0] out_g,
  input logic [7:0] out_b
);
  int col;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col <= 0;
    else if (out_valid) col <= out_sof ? 1 : ((col == W - 1) ? 0 : col + 1);
  end

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_r == 8'd0 && out_g == 8'd0 && out_b == 8'd0 && !out_sof && !out_eol));
  a_r7_sof_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  a_r7_frame_opens_sof: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sof);
  a_r7_no_gap_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eol) |=> out_valid);
  a_r7_eol_column: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof) |-> (out_eol == (col == W - 1)));
endmodule

bind sobel_close_overlay sobel_close_overlay_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_sof(out_sof),
  .out_eol(out_eol), .out_r(out_r), .out_g(out_g), .out_b(out_b)
);

// File: tb/sobel_close_overlay_test.sv
`timescale 1ns/1ps
module sobel_close_overlay_test;
  localparam int W = 10;
  localparam int H = 8;
  localparam int N = W * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0] in_gray = '0, in_r = '0, in_g = '0, in_b = '0;
  logic       out_valid, out_sof, out_eol;
  logic [7:0] out_r, out_g, out_b;

  sobel_close_overlay #(.W(W), .H(H)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_gray(in_gray), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
    .out_r(out_r), .out_g(out_g), .out_b(out_b));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0, due = -1;
  bit done = 0;
  int pgy[N], pr[N], pg[N], pb[N];
  int er[N], eg[N], eb[N], gr[N], gg[N], gb[N];
  bit raw[N], cls[N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int cl(input int v, input int hi);
    return v < 0 ? 0 : (v > hi ? hi : v);
  endfunction
  function automatic int gy_at(input int x, input int y);
    return pgy[cl(y, H - 1) * W + cl(x, W - 1)];
  endfunction
  function automatic bit map_at(input bit m[N], input int x, input int y);
    return m[cl(y, H - 1) * W + cl(x, W - 1)];
  endfunction
  function automatic int satadd(input int a, input int c);
    return (a + c > 255) ? 255 : a + c;
  endfunction

  task automatic build_model();
    bit dl[N];
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        int sx, sy;
        sx = gy_at(x+1,y-1) + 2*gy_at(x+1,y) + gy_at(x+1,y+1)
           - gy_at(x-1,y-1) - 2*gy_at(x-1,y) - gy_at(x-1,y+1);
        sy = gy_at(x-1,y+1) + 2*gy_at(x,y+1) + gy_at(x+1,y+1)
           - gy_at(x-1,y-1) - 2*gy_at(x,y-1) - gy_at(x+1,y-1);
        raw[y*W+x] = ((sx < 0 ? -sx : sx) + (sy < 0 ? -sy : sy)) > 48;
      end
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        dl[y*W+x] = map_at(raw,x,y) | map_at(raw,x-1,y) | map_at(raw,x+1,y)
                  | map_at(raw,x,y-1) | map_at(raw,x,y+1);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        int i;
        i = y*W+x;
        cls[i] = map_at(dl,x,y) & map_at(dl,x-1,y) & map_at(dl,x+1,y)
               & map_at(dl,x,y-1) & map_at(dl,x,y+1);
        er[i] = cls[i] ? satadd(pr[i], 255) : pr[i];
        eg[i] = cls[i] ? satadd(pg[i], 0)   : pg[i];
        eb[i] = cls[i] ? satadd(pb[i], 255) : pb[i];
      end
  endtask

  // R7 R6 R3 R5: per-cycle comparison against the model
  always @(negedge clk) begin
    int i;
    bit ev;
    if (rst_n && !done) begin
      i  = cyc - due;
      ev = (due >= 0) && (i >= 0) && (i < N);
      chk(out_valid === ev, "R7 out_valid timing", out_valid, ev);
      if (ev && out_valid) begin
        gr[i] = out_r; gg[i] = out_g; gb[i] = out_b;
        chk(out_r == er[i], "R6 red overlay", out_r, er[i]);
        chk(out_g == eg[i], "R6 green overlay", out_g, eg[i]);
        chk(out_b == eb[i], "R6 blue overlay", out_b, eb[i]);
        chk(out_sof == (i == 0), "R7 out_sof", out_sof, i == 0);
        chk(out_eol == ((i % W) == W - 1), "R7 out_eol", out_eol, (i % W) == W - 1);
      end
    end
  end

  task automatic drive(input bit v, input bit s, input int gyv, input int r, input int g, input int b);
    @(negedge clk);
    in_valid = v; in_sof = s;
    in_gray = 8'(gyv); in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
  endtask

  task automatic send_frame();
    for (int i = 0; i < N; i++) drive(1'b1, i == 0, pgy[i], pr[i], pg[i], pb[i]);
    build_model();
    due = cyc + 2*N + 2;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic wait_done();
    idle();
    while (cyc < due + N + 1) @(negedge clk);
  endtask

  task automatic fill(input int kind, input int a);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        int i;
        i = y*W+x;
        case (kind)
          0: pgy[i] = a;
          1: pgy[i] = (x >= 5) ? a : 0;
          2: pgy[i] = (x >= 3 && x <= 5) ? 60 : 0;
          3: pgy[i] = (x == y) ? 200 : ((y >= 4) ? 90 : 0);
          default: pgy[i] = (x*x*3 + y*17) % 256;
        endcase
        pr[i] = (kind == 2) ? 250 : (x*20 + y*3) % 256;
        pg[i] = (x*7 + y*11 + 40) % 256;
        pb[i] = (kind == 2) ? 0 : (y*30 + x) % 256;
      end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(out_valid == 0 && out_sof == 0 && out_eol == 0, "R1 markers in reset", out_valid, 0);
    chk(out_r == 0 && out_g == 0 && out_b == 0, "R1 channels in reset", out_r, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_r == 0, "R1 idle after reset", out_valid, 0);

    // R2: beats without a frame start are ignored; R4 flat frame has no border edges
    fill(0, 77);
    for (int k = 0; k < 5; k++) drive(1'b1, 1'b0, 255, 9, 9, 9);
    send_frame();
    wait_done();
    chk(gr[0] == pr[0] && gb[0] == pb[0], "R4 corner unchanged", gr[0], pr[0]);
    chk(gr[N-1] == pr[N-1], "R4 far corner unchanged", gr[N-1], pr[N-1]);

    // R3: step of 12 gives |Gx|+|Gy| = 48, not an edge
    fill(1, 12);
    send_frame();
    wait_done();
    chk(gr[3*W+4] == pr[3*W+4], "R3 sum equal to limit", gr[3*W+4], pr[3*W+4]);

    // R3: step of 13 gives 52, an edge
    fill(1, 13);
    send_frame();
    wait_done();
    chk(gr[3*W+4] == 255, "R3 sum above limit red", gr[3*W+4], 255);
    chk(gg[3*W+4] == pg[3*W+4], "R6 green kept on edge", gg[3*W+4], pg[3*W+4]);
    chk(gr[3*W+3] == pr[3*W+3], "R5 band not widened", gr[3*W+3], pr[3*W+3]);

    // R5: plateau centre column has no raw edge but is bridged
    fill(2, 0);
    send_frame();
    wait_done();
    chk(raw[2*W+4] == 0, "R5 stimulus raw gap", raw[2*W+4], 0);
    chk(gr[2*W+4] == 255 && gb[2*W+4] == 255, "R5 gap bridged", gb[2*W+4], 255);
    chk(gr[2*W+1] == pr[2*W+1], "R5 no growth outside", gr[2*W+1], pr[2*W+1]);
    chk(gb[2*W+6] == 255 && gr[2*W+6] == 255, "R6 saturating blue and red", gb[2*W+6], 255);

    // R2: sof mid-frame restarts the frame
    fill(3, 0);
    for (int k = 0; k < 30; k++) drive(1'b1, k == 0, 250, 1, 2, 3);
    send_frame();
    wait_done();
    chk(gr[0] == er[0] && gg[N-1] == eg[N-1], "R2 restart on sof", gr[0], er[0]);

    // R8: junk while busy up to the last output edge, next frame right after
    fill(4, 0);
    send_frame();
    while (cyc < due + N - 2) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (cyc % 4) == 0;
      in_gray = 8'(cyc * 37); in_r = 8'(cyc); in_g = 8'(cyc * 3); in_b = 8'(cyc * 5);
    end
    chk(cyc == due + N - 2, "R8 junk reaches last output edge", cyc, due + N - 2);
    fill(2, 0);
    send_frame();
    wait_done();
    chk(gr[2*W+4] == 255 && gg[0] == pg[0], "R8 back-to-back frame taken", gr[2*W+4], 255);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule